// File: doc/BRIEF.md
# Presettable up/down binary counter with cascade outputs

A small binary counter that steps up or down by one on each rising clock edge when its active-low enable is asserted. A direction input chooses the sense of the count. The counter wraps at both ends of its range. An active-low load input presets the state from a parallel data word. The preset takes effect as soon as load falls and does not wait for a clock edge. While load is held low, the load overrides any counting.

Two outputs let several counters be chained. The terminal-count flag is raised whenever the state sits at the end of the range in the selected direction: all ones when counting up, zero when counting down. This flag does not depend on the stage's own enable. The active-low ripple output pulses low for the low half of the clock period when the stage is enabled and at terminal count. Its rising edge therefore comes at the next rising clock edge, so it can clock the next higher stage.

Top module: `updn_counter`

## Requirements
- R1: With `cnt_en_n` = 0, `load_n` = 1 and `dir_i` = 0 (up), each rising `clk` edge changes `cnt_q` to `cnt_q` + 1.
- R2: With `cnt_en_n` = 0, `load_n` = 1 and `dir_i` = 1 (down), each rising `clk` edge changes `cnt_q` to `cnt_q` - 1.
- R3: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R4: With `cnt_en_n` = 1 and `load_n` = 1, `cnt_q` keeps its value across rising clock edges.
- R5: A falling `load_n` copies `dat_i` to `cnt_q` with no clock edge. While `load_n` stays 0, every rising clock edge reloads `dat_i` and the counting inputs have no effect.
- R6: `term_o` is 1 exactly when `dir_i` = 0 and `cnt_q` = 15, or when `dir_i` = 1 and `cnt_q` = 0. `term_o` does not depend on `cnt_en_n`.
- R7: `ripple_n_o` is 0 only while `clk` is 0, `cnt_en_n` is 0 and `term_o` is 1. At all other times it is 1.
- R8: A change on `dir_i` between clock edges leaves `cnt_q` unchanged. The new direction is applied first at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous parallel preset, active low |
| dat_i | input | 4 | Preset data |
| cnt_q | output | 4 | Counter state |
| term_o | output | 1 | Terminal-count flag |
| ripple_n_o | output | 1 | Active-low ripple clock for cascading |

## Verification
Every one of the sixteen preset values is loaded. From each one, the bench counts three steps under all four combinations of direction and enable. This covers both wrap points, shows that a held enable keeps the state, and shows the terminal flag staying up with the enable released. The ripple output is sampled in both clock phases, which separates a correct low-phase pulse from a level that ignores the clock. A load held across clock edges while the data changes separates a true preset override from a one-shot load. A direction flip between edges shows that the state is sampled, not changed at once.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/updn_next.sv
module updn_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             en_n_i,
    input  updn_pkg::dir_e   dir_i,
    output logic [WIDTH-1:0] nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (!en_n_i) begin
            if (dir_i == updn_pkg::DIR_DOWN) begin
                nxt_o = cur_i - WIDTH'(1);
            end else begin
                nxt_o = cur_i + WIDTH'(1);
            end
        end
    end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    input  updn_pkg::dir_e   dir_i,
    output logic             tc_o
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    always_comb begin
        if (dir_i == updn_pkg::DIR_DOWN) begin
            tc_o = (cur_i == '0);
        end else begin
            tc_o = (cur_i == TOP_VAL);
        end
    end

    // R6: the flag only ever marks one of the two range ends
    always_comb begin
        if (tc_o === 1'b1) begin
            assert_tc_at_end_R6: assert (cur_i == '0 || cur_i == TOP_VAL);
        end
    end
endmodule

// File: rtl/updn_ripple.sv
module updn_ripple (
    input  logic clk,
    input  logic en_n_i,
    input  logic tc_i,
    output logic ripple_n_o
);
    always_comb begin
        ripple_n_o = !(!en_n_i && tc_i && !clk);
    end

    // R7: a low ripple needs an enabled stage at terminal count
    always_comb begin
        if (ripple_n_o === 1'b0) begin
            assert_ripple_gated_R7: assert (tc_i && !en_n_i);
        end
    end
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             cnt_en_n,
    input  logic             dir_i,
    input  logic             load_n,
    input  logic [WIDTH-1:0] dat_i,
    output logic [WIDTH-1:0] cnt_q,
    output logic             term_o,
    output logic             ripple_n_o
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [WIDTH-1:0] step_val;
    updn_pkg::dir_e   dir_sel;

    assign dir_sel = updn_pkg::dir_e'(dir_i);

    updn_next #(.WIDTH(WIDTH)) u_next (
        .cur_i  (st_q.cnt),
        .en_n_i (cnt_en_n),
        .dir_i  (dir_sel),
        .nxt_o  (step_val)
    );

    updn_tc #(.WIDTH(WIDTH)) u_tc (
        .cur_i (st_q.cnt),
        .dir_i (dir_sel),
        .tc_o  (term_o)
    );

    updn_ripple u_ripple (
        .clk        (clk),
        .en_n_i     (cnt_en_n),
        .tc_i       (term_o),
        .ripple_n_o (ripple_n_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = step_val;
    end

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            st_q.cnt <= dat_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

    // R1: enabled up count advances by one
    assert_count_up_R1: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && !dir_i) |=> (cnt_q == WIDTH'($past(cnt_q) + WIDTH'(1))));

    // R2: enabled down count retreats by one
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && dir_i) |=> (cnt_q == WIDTH'($past(cnt_q) - WIDTH'(1))));

    // R3: both wrap points
    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && !dir_i && cnt_q == TOP_VAL) |=> (cnt_q == '0));
    assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && dir_i && cnt_q == '0) |=> (cnt_q == TOP_VAL));

    // R4: disabled stage holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (!load_n)
        cnt_en_n |=> $stable(cnt_q));
endmodule

// File: tb/updn_counter_test.sv
module updn_counter_test;
    logic       clk = 1'b0;
    logic       cnt_en_n = 1'b1;
    logic       dir_i = 1'b0;
    logic       load_n = 1'b0;
    logic [3:0] dat_i = 4'd0;
    logic [3:0] cnt_q;
    logic       term_o;
    logic       ripple_n_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q;

    updn_counter #(.WIDTH(4)) uut (
        .clk        (clk),
        .cnt_en_n   (cnt_en_n),
        .dir_i      (dir_i),
        .load_n     (load_n),
        .dat_i      (dat_i),
        .cnt_q      (cnt_q),
        .term_o     (term_o),
        .ripple_n_o (ripple_n_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_tc(input logic [3:0] q, input logic dn);
        return dn ? (q == 4'd0) : (q == 4'd15);
    endfunction

    // clk is low here: ripple shows its gated value
    task automatic chk_low_phase(input string tag);
        chk({tag, " R6 term"}, int'(term_o), int'(exp_tc(exp_q, dir_i)));
        chk({tag, " R7 ripple low phase"}, int'(ripple_n_o),
            int'(!(!cnt_en_n && exp_tc(exp_q, dir_i))));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state via preset
        #1;
        chk("R5 preset at time zero", int'(cnt_q), 0);

        for (int start = 0; start < 16; start++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int en = 0; en < 2; en++) begin
                    @(negedge clk);
                    dat_i    = 4'(start);
                    load_n   = 1'b1;
                    cnt_en_n = (en == 0);
                    dir_i    = 1'(dn);
                    #1;
                    load_n   = 1'b0;
                    #1;
                    chk("R5 async load without clock", int'(cnt_q), start);
                    @(posedge clk);
                    #1;
                    chk("R5 load overrides count", int'(cnt_q), start);
                    @(negedge clk);
                    load_n = 1'b1;
                    exp_q  = 4'(start);
                    #1;
                    chk("R5 value after release", int'(cnt_q), start);
                    chk_low_phase("after load");
                    for (int s = 0; s < 3; s++) begin
                        @(posedge clk);
                        #1;
                        if (en == 1) exp_q = dn ? exp_q - 4'd1 : exp_q + 4'd1;
                        chk(en == 0 ? "R4 hold" : (dn ? "R2 R3 down" : "R1 R3 up"),
                            int'(cnt_q), int'(exp_q));
                        chk("R7 ripple high phase", int'(ripple_n_o), 1);
                        @(negedge clk);
                        #1;
                        chk_low_phase("step");
                    end
                end
            end
        end

        // R5: load held low across edges follows new data
        @(negedge clk);
        cnt_en_n = 1'b0;
        dir_i    = 1'b0;
        dat_i    = 4'd9;
        load_n   = 1'b0;
        #1;
        chk("R5 hold-low load", int'(cnt_q), 9);
        dat_i = 4'd3;
        @(posedge clk);
        #1;
        chk("R5 reload on edge while low", int'(cnt_q), 3);
        @(posedge clk);
        #1;
        chk("R5 no count while low", int'(cnt_q), 3);

        // R8: direction flip between edges
        @(negedge clk);
        load_n = 1'b1;
        #1;
        dir_i = 1'b1;
        #1;
        chk("R8 no change on dir flip", int'(cnt_q), 3);
        @(posedge clk);
        #1;
        chk("R8 new dir at edge", int'(cnt_q), 2);

        // R6: flag independent of enable, at zero going down
        @(negedge clk);
        dat_i  = 4'd0;
        load_n = 1'b0;
        #1;
        load_n   = 1'b1;
        cnt_en_n = 1'b1;
        #1;
        chk("R6 term with enable off", int'(term_o), 1);
        chk("R7 ripple suppressed by enable", int'(ripple_n_o), 1);
        dir_i = 1'b0;
        #1;
        chk("R6 term follows direction", int'(term_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule